// File: doc/BRIEF.md
# Instruction-Hash Flow Monitor

This block follows a packet-processing core while it runs, one instruction at a time. For every instruction it executes, the core presents a small hash. The monitor holds a deterministic state graph in a local memory. Each graph word says which hash values may legally come next from that state, and where that state's successors begin.

If a hash is allowed, the monitor moves to the successor with a single memory lookup. The successor address is the group base plus the count of allowed hash values that are smaller than the one received. If a hash is not allowed, the monitor raises a violation. That violation is used to reset the core and to throw away the packet in flight.

The graph is written through a load port. At reset, and at the start of each packet, the walk restarts from a root state chosen by software. After a violation the monitor freezes its walk until it is reset.

Top module: `hashmon_top`

## Requirements
- R1: While and directly after `rstN` is low, `violation` is 0 and `curState` equals `rootAddr`.
- R2: A cycle with `loadEn` high writes `loadData` into graph entry `loadAddr`. The entry's fields are:
  - `loadData[15:0]` is the allowed-hash mask, where bit h set means hash value h is legal from that state.
  - `loadData[27:16]` is the 12-bit successor group base.
- R3: A legal hash is one with its mask bit set, presented with `hashValid` high while `violation` is 0 and `pktStart` is 0. The cycle after it, `curState` is `base + (number of set mask bits with index below the hash)`, taken modulo 4096, and `violation` stays 0.
- R4: An illegal hash is one with its mask bit clear, presented under the same conditions as in R3. It drives `violation` to 1 in the cycle after the hash is presented, and `curState` does not change.
- R5: Once set, `violation` stays 1 until `rstN` goes low. `pktStart` does not clear it.
- R6: While `violation` is 1, hashes are ignored: `curState` does not move on any hash, legal or not.
- R7: In a cycle with `hashValid` low and `pktStart` low, `curState` keeps its value.
- R8: A cycle with `pktStart` high loads `rootAddr` into `curState` for the next cycle. A hash presented in that same cycle is ignored, even an illegal one, and causes no violation.
- R9: Successor addresses wrap modulo 4096. Two cases show this:
  - With a full mask 0xFFFF and hash 15, the next state is base+15.
  - With base 4095 and hash 1, the next state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| rootAddr | input | 12 | State that the walk restarts from |
| pktStart | input | 1 | Start of packet; restart from the root |
| hashValid | input | 1 | `hashVal` holds a valid instruction hash |
| hashVal | input | 4 | Hash of the executed instruction |
| loadEn | input | 1 | Write strobe for the graph memory |
| loadAddr | input | 12 | Graph entry to write |
| loadData | input | 28 | Base in [27:16], mask in [15:0] |
| violation | output | 1 | Sticky deviation flag (core reset and packet drop request) |
| curState | output | 12 | Current graph state of the walk |

## Verification
Several properties are checked on every cycle:
- the violation flag stays set once it is set;
- an illegal hash in an active cycle sets the flag;
- the state holds when the cycle is idle, and holds after a violation;
- a packet start returns the walk to the root.

The successor arithmetic cannot be checked that way. This covers the rank count over the mask, the group base addition and the wrap at the top of the address space. These are shown only by the bench scenarios. The bench replays legal traces through a randomly built graph, checks each step against its own model, and then runs directed cases: full masks, base wrap, and a start that coincides with a bad hash.

// File: rtl/hashmon_pkg.sv
`timescale 1ns/1ps
package hashmon_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic goRoot;   // reload the root state
    logic advance;  // step to the computed successor
    logic flagViol; // record a deviation
  } strobe_t;
endpackage

// File: rtl/hashmon_dpath.sv
`timescale 1ns/1ps
module hashmon_dpath
  import hashmon_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int HASH_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [IDX_W-1:0]                 rootAddr,
  input  logic [HASH_W-1:0]                hashVal,
  input  logic                             loadEn,
  input  logic [IDX_W-1:0]                 loadAddr,
  input  logic [(1<<HASH_W)+IDX_W-1:0]     loadData,
  input  strobe_t                          strb,
  output logic                             maskHit,
  output logic [IDX_W-1:0]                 curState
);
  localparam int NHASH  = 1 << HASH_W;
  localparam int WORD_W = NHASH + IDX_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic [WORD_W-1:0] graphMem [DEPTH];
  logic [WORD_W-1:0] curWord;
  logic [NHASH-1:0]  allowMask;
  logic [IDX_W-1:0]  groupBase;
  logic [IDX_W-1:0]  rank;
  logic [IDX_W-1:0]  nextIdx;

  always_ff @(posedge clk) begin
    if (loadEn) graphMem[loadAddr] <= loadData;
  end

  // the single lookup per instruction
  assign curWord   = graphMem[curState];
  assign allowMask = curWord[NHASH-1:0];
  assign groupBase = curWord[WORD_W-1:NHASH];
  assign maskHit   = allowMask[hashVal];

  // rank of the hash among the allowed values
  always_comb begin
    rank = '0;
    for (int i = 0; i < NHASH; i++) begin
      if (i < int'(hashVal)) rank = rank + IDX_W'(allowMask[i]);
    end
  end

  assign nextIdx = groupBase + rank;

  always_ff @(posedge clk) begin
    if (!rstN)             curState <= rootAddr;
    else if (strb.goRoot)  curState <= rootAddr;
    else if (strb.advance) curState <= nextIdx;
  end

  // R4
  violation_no_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagViol |=> $stable(curState));
endmodule

// File: rtl/hashmon_ctrl.sv
`timescale 1ns/1ps
module hashmon_ctrl
  import hashmon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pktStart,
  input  logic    hashValid,
  input  logic    maskHit,
  output strobe_t strb,
  output logic    violation
);
  logic violReg;
  logic activeHash;

  assign activeHash    = hashValid && !pktStart && !violReg;
  assign strb.goRoot   = pktStart;
  assign strb.advance  = activeHash && maskHit;
  assign strb.flagViol = activeHash && !maskHit;

  always_ff @(posedge clk) begin
    if (!rstN)              violReg <= 1'b0;
    else if (strb.flagViol) violReg <= 1'b1;
  end

  assign violation = violReg;

  // R5
  violation_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);

  // R6
  no_step_in_violation_chk: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> !strb.advance);
endmodule

// File: rtl/hashmon_top.sv
`timescale 1ns/1ps
module hashmon_top
  import hashmon_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int HASH_W = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [IDX_W-1:0]             rootAddr,
  input  logic                         pktStart,
  input  logic                         hashValid,
  input  logic [HASH_W-1:0]            hashVal,
  input  logic                         loadEn,
  input  logic [IDX_W-1:0]             loadAddr,
  input  logic [(1<<HASH_W)+IDX_W-1:0] loadData,
  output logic                         violation,
  output logic [IDX_W-1:0]             curState
);
  strobe_t strb;
  logic    maskHit;

  hashmon_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pktStart(pktStart), .hashValid(hashValid),
    .maskHit(maskHit), .strb(strb), .violation(violation)
  );

  hashmon_dpath #(.IDX_W(IDX_W), .HASH_W(HASH_W)) i_dpath (
    .clk(clk), .rstN(rstN), .rootAddr(rootAddr), .hashVal(hashVal),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .strb(strb), .maskHit(maskHit), .curState(curState)
  );

  // R4
  illegal_sets_viol_chk: assert property (@(posedge clk) disable iff (!rstN)
    hashValid && !pktStart && !violation && !maskHit |=> violation);

  // R3
  legal_keeps_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    hashValid && !pktStart && !violation && maskHit |=> !violation);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hashValid && !pktStart |=> $stable(curState));

  // R6
  frozen_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    violation && !pktStart |=> $stable(curState));

  // R8
  root_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktStart |=> curState == $past(rootAddr));

  // R8
  start_masks_hash_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktStart && !violation |=> !violation);
endmodule

// File: tb/test_hashmon_top.sv
`timescale 1ns/1ps
module test_hashmon_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] rootAddr;
  logic        pktStart;
  logic        hashValid;
  logic [3:0]  hashVal;
  logic        loadEn;
  logic [11:0] loadAddr;
  logic [27:0] loadData;
  logic        violation;
  logic [11:0] curState;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [27:0] model [4096];
  logic [11:0] expState;
  logic        expViol;

  always #5 clk = ~clk;

  hashmon_top i_hashmon_top (
    .clk(clk), .rstN(rstN), .rootAddr(rootAddr), .pktStart(pktStart),
    .hashValid(hashValid), .hashVal(hashVal), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadData(loadData), .violation(violation),
    .curState(curState)
  );

  function automatic logic [11:0] popBelow(input logic [15:0] m, input logic [3:0] h);
    logic [11:0] c = '0;
    for (int i = 0; i < 16; i++) if (i < int'(h)) c = c + 12'(m[i]);
    return c;
  endfunction

  function automatic int popAll(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (curState !== expState) begin
      errors++;
      $display("FAIL %s curState actual %0d expected %0d", tag, curState, expState);
    end
    checks++;
    if (violation !== expViol) begin
      errors++;
      $display("FAIL %s violation actual %0b expected %0b", tag, violation, expViol);
    end
  endtask

  task automatic loadWord(input logic [11:0] a, input logic [15:0] m, input logic [11:0] b);
    loadEn = 1'b1; loadAddr = a; loadData = {b, m};
    @(posedge clk); #1;
    loadEn = 1'b0;
    model[a] = {b, m};
  endtask

  task automatic step(input logic v, input logic [3:0] h, input logic s);
    logic [27:0] w;
    hashValid = v; hashVal = h; pktStart = s;
    @(posedge clk); #1;
    if (s) expState = rootAddr;
    else if (v && !expViol) begin
      w = model[expState];
      if (w[h]) expState = w[27:16] + popBelow(w[15:0], h);
      else expViol = 1'b1;
    end
    hashValid = 1'b0; pktStart = 1'b0;
  endtask

  function automatic logic [3:0] pickHash(input logic [15:0] m, input bit legal, input int start);
    for (int k = 0; k < 16; k++) begin
      logic [3:0] h = 4'((start + k) % 16);
      if (m[h] == legal) return h;
    end
    return 4'(start);
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; rootAddr = 12'd0; pktStart = 1'b0; hashValid = 1'b0;
    hashVal = 4'd0; loadEn = 1'b0; loadAddr = '0; loadData = '0;
    expState = 12'd0; expViol = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset");

    // R2: graph of 32 states, each with one clear mask bit, successors kept inside 0..31
    for (int a = 0; a < 32; a++) begin
      logic [15:0] m;
      int pc;
      m = 16'($urandom()) | 16'h0001;
      m = m & ~(16'h0001 << (1 + $urandom() % 15));
      pc = popAll(m);
      loadWord(12'(a), m, 12'($urandom() % (33 - pc)));
    end
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after release");

    // R3 / R7: random legal trace with idle gaps
    for (int n = 0; n < 300; n++) begin
      if ($urandom() % 4 == 0) begin
        step(1'b0, 4'($urandom()), 1'b0);
        check("R7 idle hold");
      end else begin
        step(1'b1, pickHash(model[expState][15:0], 1'b1, int'($urandom() % 16)), 1'b0);
        check("R3 legal step");
      end
    end

    // R8: packet start, then more legal steps
    step(1'b0, 4'd0, 1'b1);
    check("R8 start to root");
    for (int n = 0; n < 20; n++) begin
      step(1'b1, pickHash(model[expState][15:0], 1'b1, int'($urandom() % 16)), 1'b0);
      check("R2 R3 legal step");
    end

    // R4: illegal hash
    step(1'b1, pickHash(model[expState][15:0], 1'b0, int'($urandom() % 16)), 1'b0);
    check("R4 illegal hash");

    // R6: hashes ignored while violating
    for (int n = 0; n < 10; n++) begin
      step(1'b1, 4'($urandom()), 1'b0);
      check("R6 ignored hash");
    end

    // R5: sticky through start
    rootAddr = 12'd5;
    step(1'b0, 4'd0, 1'b1);
    check("R5 sticky over start");
    step(1'b1, 4'd0, 1'b0);
    check("R5 R6 still frozen");

    // R1: reset clears the flag
    rstN = 1'b0;
    @(posedge clk); #1;
    expState = rootAddr; expViol = 1'b0;
    check("R1 reset clears");
    rstN = 1'b1;

    // R8: start wins over a simultaneous illegal hash
    rootAddr = 12'd3;
    step(1'b1, pickHash(model[expState][15:0], 1'b0, 0), 1'b1);
    check("R8 start beats hash");

    // R9: wrap and full mask
    loadWord(12'd4095, 16'hFFFF, 12'd4095);
    rootAddr = 12'd4095;
    step(1'b0, 4'd0, 1'b1);
    check("R8 root 4095");
    step(1'b1, 4'd1, 1'b0);
    check("R9 wrap to 0");
    if (expState !== 12'd0) begin
      errors++;
      $display("FAIL R9 model actual %0d expected 0", expState);
    end
    step(1'b0, 4'd0, 1'b1);
    step(1'b1, 4'd15, 1'b0);
    check("R9 full mask hash 15");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule